// File: doc/BRIEF.md
# Staggered Round-Robin Refresh Scheduler

This block decides when each rank of a memory needs a refresh. Every rank has its own down-counter. After reset the counters start at staggered values, so the ranks reach zero at evenly spaced points inside one refresh interval. The interval in clock cycles is the refresh period divided by the clock period, using integer division.

A round-robin pointer selects the single rank whose counter is tested for zero in a given cycle. When the counter of the selected rank is zero, three things happen: the rank is marked as waiting for refresh, its counter is reloaded, and the pointer moves to the next rank.

Waiting ranks are presented one at a time on a request/acknowledge pair. The presented request is held until the command side acknowledges it. Issuing the refresh command itself, and any bank timing that follows it, is left to the surrounding controller.

The presentation logic is a two-state machine:
- `RS_IDLE`: no request is shown.
- `RS_HOLD`: `ref_req` is high and `ref_rank` names the rank.

It has three transitions:
- **present**: `RS_IDLE` to `RS_HOLD`, taken when the rank under the service pointer is waiting.
- **keep**: `RS_HOLD` to `RS_HOLD`, taken while no acknowledge arrives.
- **retire**: `RS_HOLD` to `RS_IDLE`, taken on an acknowledge. It clears that rank's waiting flag and advances the service pointer.

Top module: `refresh_sched`

## Requirements
- R1: The interval is `T_REFRESH_PS / T_CLK_PS` cycles. At reset, rank i's counter holds `(interval / NUM_RANKS) * (i + 1)`. All counters count down by one per clock edge. A counter that is tested while it holds zero marks its rank waiting on that edge.
- R2: Only the counter of the rank under the expiry pointer is tested. Any other counter that reaches zero stays at zero and never wraps. No counter ever exceeds the interval.
- R3: On each expiry the expiry pointer advances by one, wrapping from the last rank to rank 0. Ranks are therefore requested in the order 0, 1, ..., NUM_RANKS-1, 0, ...
- R4: At most one rank is marked waiting on any clock edge.
- R5: On expiry the counter is reloaded to the interval and decremented on the same edge, so the counter holds interval-1 afterwards. Successive expiries of one rank are therefore exactly `interval` cycles apart.
- R6: A waiting rank keeps its flag until acknowledged. While `ref_req` is high and `ref_ack` is low, the next cycle shows `ref_req` high with the same `ref_rank`.
- R7: `ref_ack` asserted while `ref_req` is low changes no state and no output.
- R8: An acknowledge while `ref_req` is high makes `ref_req` low in the next cycle. The next waiting rank in round-robin order is presented one cycle after that.
- R9: During and immediately after reset, `ref_req` is low and `ref_rank` is 0.
- R10: An expiry for a rank that is already waiting merges into the pending request. If that expiry falls on the same edge as the rank's acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ack | input | 1 | Refresh done for the presented rank |
| ref_req | output | 1 | A rank is waiting for refresh |
| ref_rank | output | RANK_W | Index of the rank being requested |

## Verification
The bench builds the block with four ranks, a 40 ns refresh period and a 1 ns clock. This gives an interval of 40 cycles and a stagger of 10 cycles, so every rank expires several times within a few thousand cycles. Prompt acknowledges show the exact first-request cycles and the rank order. Long acknowledge delays make the expiry pointer lap the service pointer, which forces merged requests and expiries that coincide with acknowledges. Acknowledges with no request pending are also driven, to confirm that they change nothing.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HOLD = 1'b1
    } req_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/refresh_rank_timers.sv
module refresh_rank_timers #(
    parameter int NUM_RANKS = 4,
    parameter int INTERVAL  = 40,
    parameter int RANK_W    = 2,
    parameter int CNT_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              expire,
    output logic [RANK_W-1:0] exp_ptr,
    output logic [CNT_W-1:0]  cur_cnt
);
    localparam int STAGGER = INTERVAL / NUM_RANKS;

    logic [CNT_W-1:0] cnt [NUM_RANKS];
    logic [RANK_W-1:0] ptr_q;

    always_comb begin
        cur_cnt = '0;
        for (int k = 0; k < NUM_RANKS; k++) begin
            if (ptr_q == RANK_W'(k)) cur_cnt = cnt[k];
        end
    end

    assign expire  = (cur_cnt == '0);
    assign exp_ptr = ptr_q;

    generate
        for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
            localparam logic [CNT_W-1:0] START_VAL = CNT_W'(STAGGER * (i + 1));
            logic hit;
            assign hit = expire && (ptr_q == RANK_W'(i));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt[i] <= START_VAL;
                end else if (hit) begin
                    cnt[i] <= CNT_W'(INTERVAL - 1);
                end else if (cnt[i] != '0) begin
                    cnt[i] <= cnt[i] - 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (expire) begin
            if (ptr_q == RANK_W'(NUM_RANKS - 1)) ptr_q <= '0;
            else                                 ptr_q <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_wait_flags.sv
module refresh_wait_flags #(
    parameter int NUM_RANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RANKS-1:0] set_vec,
    input  logic [NUM_RANKS-1:0] clr_vec,
    output logic [NUM_RANKS-1:0] waiting
);
    generate
        for (genvar i = 0; i < NUM_RANKS; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n)          waiting[i] <= 1'b0;
                else if (set_vec[i]) waiting[i] <= 1'b1;
                else if (clr_vec[i]) waiting[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/refresh_req_fsm.sv
module refresh_req_fsm
    import refresh_sched_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int RANK_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RANKS-1:0] waiting,
    input  logic                 ack,
    output logic                 req,
    output logic [RANK_W-1:0]    req_rank,
    output logic [NUM_RANKS-1:0] clr_vec
);
    req_state_e state_q, state_d;
    logic [RANK_W-1:0] srv_q;
    logic srv_waiting;
    logic retire;

    always_comb begin
        srv_waiting = 1'b0;
        for (int k = 0; k < NUM_RANKS; k++) begin
            if (srv_q == RANK_W'(k)) srv_waiting = waiting[k];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (srv_waiting) state_d = RS_HOLD;
            RS_HOLD: if (ack)         state_d = RS_IDLE;
            default:                  state_d = RS_IDLE;
        endcase
    end

    assign retire = (state_q == RS_HOLD) && ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            srv_q   <= '0;
        end else begin
            state_q <= state_d;
            if (retire) begin
                if (srv_q == RANK_W'(NUM_RANKS - 1)) srv_q <= '0;
                else                                 srv_q <= srv_q + 1'b1;
            end
        end
    end

    always_comb begin
        req      = 1'b0;
        req_rank = srv_q;
        clr_vec  = '0;
        unique case (state_q)
            RS_IDLE: req = 1'b0;
            RS_HOLD: begin
                req = 1'b1;
                for (int k = 0; k < NUM_RANKS; k++) begin
                    clr_vec[k] = ack && (srv_q == RANK_W'(k));
                end
            end
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int NUM_RANKS    = 4,
    parameter int T_REFRESH_PS = 40000,
    parameter int T_CLK_PS     = 1000,
    parameter int RANK_W       = idx_width(NUM_RANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_ack,
    output logic              ref_req,
    output logic [RANK_W-1:0] ref_rank
);
    localparam int INTERVAL = T_REFRESH_PS / T_CLK_PS;
    localparam int CNT_W    = $clog2(INTERVAL + 1);

    logic                 expire;
    logic [RANK_W-1:0]    exp_ptr;
    logic [CNT_W-1:0]     cur_cnt;
    logic [NUM_RANKS-1:0] set_vec;
    logic [NUM_RANKS-1:0] clr_vec;
    logic [NUM_RANKS-1:0] waiting;

    refresh_rank_timers #(
        .NUM_RANKS(NUM_RANKS), .INTERVAL(INTERVAL), .RANK_W(RANK_W), .CNT_W(CNT_W)
    ) u_timers (
        .clk(clk), .rst_n(rst_n), .expire(expire), .exp_ptr(exp_ptr), .cur_cnt(cur_cnt)
    );

    generate
        for (genvar i = 0; i < NUM_RANKS; i++) begin : g_set
            assign set_vec[i] = expire && (exp_ptr == RANK_W'(i));
        end
    endgenerate

    refresh_wait_flags #(.NUM_RANKS(NUM_RANKS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .waiting(waiting)
    );

    refresh_req_fsm #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .waiting(waiting), .ack(ref_ack),
        .req(ref_req), .req_rank(ref_rank), .clr_vec(clr_vec)
    );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int NUM_RANKS = 4,
    parameter int RANK_W    = 2,
    parameter int CNT_W     = 6,
    parameter int INTERVAL  = 40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_ack,
    input logic                 ref_req,
    input logic [RANK_W-1:0]    ref_rank,
    input logic                 expire,
    input logic [RANK_W-1:0]    exp_ptr,
    input logic [CNT_W-1:0]     cur_cnt,
    input logic [NUM_RANKS-1:0] set_vec
);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack) |=> (ref_req && $stable(ref_rank)));

    p_drop_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack) |=> !ref_req);

    p_one_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (exp_ptr == (($past(exp_ptr) == RANK_W'(NUM_RANKS - 1)) ? '0 : $past(exp_ptr) + 1'b1)));

    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> $stable(exp_ptr));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_cnt <= CNT_W'(INTERVAL));

    p_ack_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && ref_ack) |=> $stable(ref_rank));
endmodule

bind refresh_sched refresh_sched_chk #(
    .NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W), .CNT_W(CNT_W), .INTERVAL(INTERVAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_req(ref_req), .ref_rank(ref_rank),
    .expire(expire), .exp_ptr(exp_ptr), .cur_cnt(cur_cnt), .set_vec(set_vec)
);

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
    localparam int N       = 4;
    localparam int TREF_PS = 40000;
    localparam int TCK_PS  = 1000;
    localparam int IVL     = TREF_PS / TCK_PS;
    localparam int RW      = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_ack = 1'b0;
    logic ref_req;
    logic [RW-1:0] ref_rank;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    int  m_cnt [N];
    int  m_ptr, m_srv;
    bit  m_flg [N];
    bit  m_hold;

    always #5 clk = ~clk;

    refresh_sched #(.NUM_RANKS(N), .T_REFRESH_PS(TREF_PS), .T_CLK_PS(TCK_PS)) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_req(ref_req), .ref_rank(ref_rank)
    );

    function automatic int start_count(input int r);
        return (IVL / N) * (r + 1);
    endfunction

    function automatic int next_idx(input int r);
        return (r == N - 1) ? 0 : r + 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = start_count(i);
            m_flg[i] = 1'b0;
        end
        m_ptr = 0; m_srv = 0; m_hold = 1'b0;
    endtask

    task automatic model_step(input bit a);
        bit exp_now, clr, srv_w;
        int eptr;
        exp_now = (m_cnt[m_ptr] == 0);
        eptr    = m_ptr;
        clr     = m_hold && a;
        srv_w   = m_flg[m_srv];
        for (int i = 0; i < N; i++) begin
            if (exp_now && eptr == i)   m_flg[i] = 1'b1;
            else if (clr && m_srv == i) m_flg[i] = 1'b0;
            if (exp_now && eptr == i)   m_cnt[i] = IVL - 1;
            else if (m_cnt[i] > 0)      m_cnt[i] = m_cnt[i] - 1;
        end
        if (exp_now) m_ptr = next_idx(m_ptr);
        if (m_hold)  m_hold = !a;
        else         m_hold = srv_w;
        if (clr)     m_srv = next_idx(m_srv);
    endtask

    task automatic compare(input string tag);
        check(tag, int'(ref_req), int'(m_hold));
        check(tag, int'(ref_rank), m_srv);
    endtask

    task automatic cycle(input bit a);
        ref_ack = a;
        @(posedge clk);
        model_step(a);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        int rise_cnt;
        int last_cyc;
        int cyc;
        bit prev_req;
        bit prev_ack;
        string tag;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        check("R9 req in reset", int'(ref_req), 0);
        check("R9 rank in reset", int'(ref_rank), 0);
        rst_n = 1'b1;
        check("R9 req after reset", int'(ref_req), 0);

        // directed: prompt acks, first five requests, exact cycles and order
        rise_cnt = 0; cyc = 0; prev_req = 1'b0; last_cyc = 0;
        while (rise_cnt < 5 && cyc < 200) begin
            cycle(ref_req);
            cyc++;
            if (ref_req && !prev_req) begin
                check("R1 R5 first-request cycle", cyc, 12 + 10 * rise_cnt);
                check("R3 R4 rank order", int'(ref_rank), rise_cnt % N);
                if (rise_cnt == 4) check("R5 same-rank spacing", cyc - last_cyc, 4 * 10);
                if (rise_cnt == 0) last_cyc = cyc;
                rise_cnt++;
            end
            if (prev_req && !ref_req) check("R8 drop after ack", int'(ref_req), 0);
            prev_req = ref_req;
            compare("R2 model");
        end
        check("R3 five requests seen", rise_cnt, 5);

        // random ack pattern against the model
        prev_ack = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            bit a;
            prev_req = ref_req;
            a = ref_req ? ($urandom % 6 == 0) : ($urandom % 5 == 0);
            cycle(a);
            if (prev_req && a)       tag = "R8 after ack";
            else if (prev_req)       tag = "R6 hold";
            else if (a)              tag = "R7 ack without req";
            else                     tag = "R10 model";
            compare(tag);
        end

        // directed: long hold so the expiry pointer laps the service pointer
        while (!ref_req) cycle(1'b0);
        begin
            int held_rank;
            held_rank = int'(ref_rank);
            for (int k = 0; k < 3 * IVL; k++) begin
                cycle(1'b0);
                check("R6 held request", int'(ref_req), 1);
                check("R6 held rank", int'(ref_rank), held_rank);
            end
            for (int k = 0; k < 3 * N; k++) begin
                cycle(ref_req);
                compare("R10 merged drain");
            end
        end
        // idle acks with nothing pending
        for (int k = 0; k < 200; k++) begin
            cycle(!ref_req);
            compare("R7 idle ack");
        end
        finish_run();
    end

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule